// File: doc/BRIEF.md
# Dual-Channel UART FIFO Register Port

This block sits between a simple synchronous host bus and the data FIFOs of a two-channel UART. Each channel holds a 64-entry transmit queue and a 64-entry receive queue, and the receive queue keeps an 8-bit line-status tag next to every data byte. One host access can move one, two, three or four bytes. The four byte enables pick the lanes, and each queue pointer advances by exactly the number of bytes moved. A second receive location returns every byte paired with its tag, so that data and error status cannot drift apart.

The bus address is a byte address. The top bit selects the channel, and each channel owns a 512-byte window. The lower two address bits are ignored, so the byte enables alone choose the lanes. Channel 0's window also holds a small device-wide area at offsets 0x080 to 0x093. The serial side is modelled as plain FIFO ports: the transmitter pops bytes from the transmit queue, and the receiver pushes data and tag pairs into the receive queue.

Top module: `uart_fifo_regport`

## Requirements
- R1: Address bit 9 selects the channel (0 or 1). Bits 8:2 select the word inside the channel's 512-byte window: 0x000 is the level/status word, 0x100 is the data location and 0x180 is the paired receive location.
- R2: A write to the data location pushes one transmit entry for each enabled byte lane. The lowest enabled lane becomes the oldest entry, and the pointer advances by the number of enabled lanes.
- R3: A read of the data location pops one receive entry for each enabled lane. The oldest entry goes to the lowest enabled lane, the data byte only, and the following entries fill the higher enabled lanes in order.
- R4: A paired read uses byte enables 0011, 1100 or 1111. Each fully enabled 16-bit half returns {tag[7:0], data[7:0]} (data in the low byte) and pops one entry, the lower half taking the older entry. Any other byte-enable pattern returns zero and pops nothing.
- R5: A read from an empty or short receive queue returns zero in the lanes that have no entry and never moves the pointer past the stored entries.
- R6: Bytes pushed into a full queue are dropped and leave the stored entries intact. A dropped host transmit byte sets a sticky transmit-overflow flag, and a receive push into a full queue sets a sticky receive-overflow flag. Both flags clear after any read of the level word with lane 2 enabled.
- R7: The level word reads byte0 = transmit count (0..64), byte1 = receive count (0..64), byte2 bit0 = transmit overflow, byte2 bit1 = receive overflow, and the other bits zero.
- R8: In channel 0's window, 0x080 reads {ch1 rx count, ch1 tx count, ch0 rx count, ch0 tx count} from byte3 down to byte0. 0x084 is a 32-bit scratch word written per byte lane, reset to zero. 0x088 to 0x093 read zero. The same offsets in channel 1 read zero.
- R9: Read data appears on bus_rdata on the clock edge that completes the read access and holds until the next read. Lanes that are not enabled read zero. After reset bus_rdata is zero.
- R10: tx_head shows the oldest transmit entry and tx_empty is high when the transmit queue is empty. A pulse on rx_push stores rx_byte and rx_tag as one receive entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_pop | input | 2 | Serial side takes the head transmit byte, per channel |
| tx_head | output | 16 | Oldest transmit byte, 8 bits per channel |
| tx_empty | output | 2 | Transmit queue empty, per channel |
| rx_push | input | 2 | Serial side stores one receive entry, per channel |
| rx_byte | input | 16 | Receive data byte, 8 bits per channel |
| rx_tag | input | 16 | Receive status tag, 8 bits per channel |
| rx_full | output | 2 | Receive queue full, per channel |

## Verification
On every cycle, the assertions check the following. Queue counts stay within 64. An empty queue with no push stays empty, and a full queue with no pop stays full. The overflow flags stay set until a clearing read. A malformed paired read never lowers the receive count. Read data holds between reads, and disabled lanes read zero.

Only the bench's scenarios can show the rest. These are the byte ordering across lanes, the pairing of each byte with its own tag, the exact number of entries each access moves, and the fact that dropped bytes leave older entries intact. The bench also covers the device window contents and the separation of the two channels. It checks all of these against a queue model, under random mixes of widths and serial traffic.

// File: rtl/uart_rp_pkg.sv
package uart_rp_pkg;
  localparam int LANES = 4;
  localparam int WIN_BITS = 9;
  // word offsets (byte offset >> 2) inside a channel window
  localparam logic [6:0] W_LEVEL   = 7'h00;
  localparam logic [6:0] W_SNAP    = 7'h20;
  localparam logic [6:0] W_SCRATCH = 7'h21;
  localparam logic [6:0] W_DATA    = 7'h40;
  localparam logic [6:0] W_PAIR    = 7'h60;
endpackage

// File: rtl/uart_rp_fifo.sv
module uart_rp_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 64,
  parameter int PORTS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int NW = $clog2(PORTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NW-1:0]      push_n,
  input  logic [PORTS*W-1:0] push_data,
  input  logic [NW-1:0]      pop_n,
  output logic [PORTS*W-1:0] peek,
  output logic [CW-1:0]      count,
  output logic               push_drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d, free, push_req, pop_req, push_acc, pop_acc;

  always_comb begin
    free     = CW'(DEPTH) - cnt_q;
    push_req = CW'(push_n);
    pop_req  = CW'(pop_n);
    push_acc = (push_req > free) ? free : push_req;
    pop_acc  = (pop_req > cnt_q) ? cnt_q : pop_req;
    wp_d     = wp_q + AW'(push_acc);
    rp_d     = rp_q + AW'(pop_acc);
    cnt_d    = cnt_q + push_acc - pop_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PORTS; i++) begin
      if (CW'(i) < push_acc) mem[wp_q + AW'(i)] <= push_data[i*W +: W];
    end
  end

  always_comb begin
    for (int i = 0; i < PORTS; i++) begin
      peek[i*W +: W] = (CW'(i) < cnt_q) ? mem[rp_q + AW'(i)] : '0;
    end
  end

  assign count     = cnt_q;
  assign push_drop = (push_acc != push_req);

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r5_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && push_n == '0) |=> cnt_q == '0);
  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && pop_n == '0) |=> cnt_q == CW'(DEPTH));
endmodule

// File: rtl/uart_rp_chan.sv
module uart_rp_chan #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          rd_data,
  input  logic          rd_pair,
  input  logic          rd_level,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  input  logic          tx_pop,
  output logic [7:0]    tx_head,
  output logic          tx_empty,
  input  logic          rx_push,
  input  logic [7:0]    rx_byte,
  input  logic [7:0]    rx_tag,
  output logic          rx_full,
  output logic [31:0]   data_lanes,
  output logic [31:0]   pair_lanes,
  output logic [31:0]   level_word,
  output logic [CW-1:0] tx_cnt,
  output logic [CW-1:0] rx_cnt
);
  logic [31:0] tx_vec, tx_peek;
  logic [63:0] rx_peek;
  logic [2:0]  n_w, n_r, n_p, tx_push_n, rx_pop_n;
  logic        pair_ok, tx_drop, rx_drop;
  logic        tx_ovf_q, tx_ovf_d, rx_ovf_q, rx_ovf_d, clr;

  always_comb begin
    tx_vec = '0; data_lanes = '0; pair_lanes = '0;
    n_w = '0; n_r = '0; n_p = '0;
    pair_ok = (be == 4'b0011) || (be == 4'b1100) || (be == 4'b1111);
    for (int k = 0; k < 4; k++) begin
      if (be[k]) begin
        tx_vec[n_w*8 +: 8]     = wdata[k*8 +: 8];
        data_lanes[k*8 +: 8]   = rx_peek[n_r*16 +: 8];
        n_w = n_w + 3'd1;
        n_r = n_r + 3'd1;
      end
    end
    for (int h = 0; h < 2; h++) begin
      if (pair_ok && be[h*2 +: 2] == 2'b11) begin
        pair_lanes[h*16 +: 16] = rx_peek[n_p*16 +: 16];
        n_p = n_p + 3'd1;
      end
    end
    tx_push_n = wr_data ? n_w : 3'd0;
    rx_pop_n  = rd_data ? n_r : (rd_pair ? n_p : 3'd0);
  end

  uart_rp_fifo #(.W(8), .DEPTH(DEPTH), .PORTS(4)) u_tx (
    .clk(clk), .rst_n(rst_n), .push_n(tx_push_n), .push_data(tx_vec),
    .pop_n({2'b00, tx_pop}), .peek(tx_peek), .count(tx_cnt), .push_drop(tx_drop));

  uart_rp_fifo #(.W(16), .DEPTH(DEPTH), .PORTS(4)) u_rx (
    .clk(clk), .rst_n(rst_n), .push_n({2'b00, rx_push}),
    .push_data({48'd0, rx_tag, rx_byte}), .pop_n(rx_pop_n), .peek(rx_peek),
    .count(rx_cnt), .push_drop(rx_drop));

  always_comb begin
    clr      = rd_level && be[2];
    tx_ovf_d = tx_drop || (tx_ovf_q && !clr);
    rx_ovf_d = rx_drop || (rx_ovf_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf_q <= 1'b0;
      rx_ovf_q <= 1'b0;
    end else begin
      tx_ovf_q <= tx_ovf_d;
      rx_ovf_q <= rx_ovf_d;
    end
  end

  assign tx_head    = tx_peek[7:0];
  assign tx_empty   = (tx_cnt == '0);
  assign rx_full    = (rx_cnt == CW'(DEPTH));
  assign level_word = {8'd0, 6'd0, rx_ovf_q, tx_ovf_q, 8'(rx_cnt), 8'(tx_cnt)};

  a_r6_sticky_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf_q && !(rd_level && be[2])) |=> tx_ovf_q);
  a_r6_sticky_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf_q && !(rd_level && be[2])) |=> rx_ovf_q);
  a_r4_bad_pair_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pair && be != 4'b0011 && be != 4'b1100 && be != 4'b1111)
      |=> rx_cnt >= $past(rx_cnt));
endmodule

// File: rtl/uart_fifo_regport.sv
module uart_fifo_regport
  import uart_rp_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DEPTH = 64,
  localparam int CHB = $clog2(NCH),
  localparam int ADDR_W = WIN_BITS + CHB,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    tx_pop,
  output logic [NCH*8-1:0]  tx_head,
  output logic [NCH-1:0]    tx_empty,
  input  logic [NCH-1:0]    rx_push,
  input  logic [NCH*8-1:0]  rx_byte,
  input  logic [NCH*8-1:0]  rx_tag,
  output logic [NCH-1:0]    rx_full
);
  logic [CHB-1:0] ch;
  logic [6:0]     wofs;
  logic           is_rd, is_wr;
  logic [31:0]    data_w [NCH];
  logic [31:0]    pair_w [NCH];
  logic [31:0]    lvl_w  [NCH];
  logic [CW-1:0]  txc [NCH];
  logic [CW-1:0]  rxc [NCH];
  logic [31:0]    snap, rd_val, rd_mask, rdata_q, rdata_d, scr_q, scr_d;

  assign ch    = bus_addr[ADDR_W-1:WIN_BITS];
  assign wofs  = bus_addr[WIN_BITS-1:2];
  assign is_rd = bus_sel && !bus_wr;
  assign is_wr = bus_sel && bus_wr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = (ch == CHB'(c));
    uart_rp_chan #(.DEPTH(DEPTH)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_data(is_wr && hit && wofs == W_DATA),
      .rd_data(is_rd && hit && wofs == W_DATA),
      .rd_pair(is_rd && hit && wofs == W_PAIR),
      .rd_level(is_rd && hit && wofs == W_LEVEL),
      .be(bus_be), .wdata(bus_wdata),
      .tx_pop(tx_pop[c]), .tx_head(tx_head[c*8 +: 8]), .tx_empty(tx_empty[c]),
      .rx_push(rx_push[c]), .rx_byte(rx_byte[c*8 +: 8]), .rx_tag(rx_tag[c*8 +: 8]),
      .rx_full(rx_full[c]),
      .data_lanes(data_w[c]), .pair_lanes(pair_w[c]), .level_word(lvl_w[c]),
      .tx_cnt(txc[c]), .rx_cnt(rxc[c]));
  end

  always_comb begin
    snap = '0;
    for (int c = 0; c < NCH && c < 2; c++) begin
      snap[c*16 +: 16] = {8'(rxc[c]), 8'(txc[c])};
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (wofs)
      W_LEVEL:   rd_val = lvl_w[ch];
      W_DATA:    rd_val = data_w[ch];
      W_PAIR:    rd_val = pair_w[ch];
      W_SNAP:    rd_val = (ch == '0) ? snap : '0;
      W_SCRATCH: rd_val = (ch == '0) ? scr_q : '0;
      default:   rd_val = '0;
    endcase
    rd_mask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
    rdata_d = is_rd ? (rd_val & rd_mask) : rdata_q;
    scr_d   = scr_q;
    if (is_wr && ch == '0 && wofs == W_SCRATCH) begin
      for (int k = 0; k < 4; k++) begin
        if (bus_be[k]) scr_d[k*8 +: 8] = bus_wdata[k*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      scr_q   <= '0;
    end else begin
      rdata_q <= rdata_d;
      scr_q   <= scr_d;
    end
  end

  assign bus_rdata = rdata_q;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
  a_r9_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_be == 4'b0001) |=> bus_rdata[31:8] == 24'd0);
endmodule

// File: tb/uart_fifo_regport_tb.sv
`timescale 1ns/1ps
module uart_fifo_regport_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [9:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  tx_pop, tx_empty, rx_push, rx_full;
  logic [15:0] tx_head, rx_byte, rx_tag;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  txq [2][$];
  logic [15:0] rxq [2][$];
  logic        txo [2];
  logic        rxo [2];
  logic [31:0] scr;

  always #2 clk = ~clk;

  uart_fifo_regport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_pop(tx_pop), .tx_head(tx_head),
    .tx_empty(tx_empty), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_tag(rx_tag), .rx_full(rx_full));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [3:0] rand_be();
    int st = int'($urandom % 4);
    int ln = 1 + int'($urandom % (4 - st));
    return 4'(((1 << ln) - 1) << st);
  endfunction

  task automatic bus_do(input logic wr, input int ch, input logic [8:0] off,
                        input logic [3:0] be, input logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = {ch[0], off}; bus_be = be; bus_wdata = wd;
    @(posedge clk);
    #1;
    rd = bus_rdata;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // model + access: transmit data write (R2, R6)
  task automatic tx_write(input int ch, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] rd;
    for (int k = 0; k < 4; k++)
      if (be[k]) begin
        if (txq[ch].size() < 64) txq[ch].push_back(wd[k*8 +: 8]);
        else txo[ch] = 1'b1;
      end
    bus_do(1'b1, ch, 9'h100, be, wd, rd);
  endtask

  // receive data read (R1, R3, R5)
  task automatic rx_read(input int ch, input logic [3:0] be, input string req);
    logic [31:0] exp, rd;
    exp = '0;
    for (int k = 0; k < 4; k++)
      if (be[k] && rxq[ch].size() > 0) exp[k*8 +: 8] = rxq[ch].pop_front()[7:0];
    bus_do(1'b0, ch, 9'h100, be, 32'd0, rd);
    check(req, rd, exp);
  endtask

  // paired read (R4)
  task automatic pair_read(input int ch, input logic [3:0] be, input string req);
    logic [31:0] exp, rd;
    exp = '0;
    if (be == 4'b0011 || be == 4'b1100 || be == 4'b1111)
      for (int h = 0; h < 2; h++)
        if (be[h*2 +: 2] == 2'b11 && rxq[ch].size() > 0) exp[h*16 +: 16] = rxq[ch].pop_front();
    bus_do(1'b0, ch, 9'h180, be, 32'd0, rd);
    check(req, rd, exp);
  endtask

  // level word (R7, R6)
  task automatic lvl_read(input int ch, input logic [3:0] be, input string req);
    logic [31:0] exp, rd;
    exp = {14'd0, rxo[ch], txo[ch], 8'(rxq[ch].size()), 8'(txq[ch].size())} & lane_mask(be);
    if (be[2]) begin txo[ch] = 1'b0; rxo[ch] = 1'b0; end
    bus_do(1'b0, ch, 9'h000, be, 32'd0, rd);
    check(req, rd, exp);
  endtask

  // device area (R8)
  task automatic dev_read(input int ch, input logic [8:0] off, input logic [3:0] be, input string req);
    logic [31:0] exp, rd;
    exp = '0;
    if (ch == 0 && off == 9'h080)
      exp = {8'(rxq[1].size()), 8'(txq[1].size()), 8'(rxq[0].size()), 8'(txq[0].size())};
    else if (ch == 0 && off == 9'h084) exp = scr;
    exp &= lane_mask(be);
    bus_do(1'b0, ch, off, be, 32'd0, rd);
    check(req, rd, exp);
  endtask

  task automatic scr_write(input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] rd;
    for (int k = 0; k < 4; k++) if (be[k]) scr[k*8 +: 8] = wd[k*8 +: 8];
    bus_do(1'b1, 0, 9'h084, be, wd, rd);
  endtask

  // serial side (R10)
  task automatic ser_pop(input int ch);
    @(negedge clk);
    check("R10 tx_empty", 32'(tx_empty[ch]), 32'(txq[ch].size() == 0));
    if (txq[ch].size() > 0) check("R10/R2 tx_head order", 32'(tx_head[ch*8 +: 8]), 32'(txq[ch].pop_front()));
    tx_pop[ch] = 1'b1;
    @(posedge clk);
    #1 tx_pop = '0;
  endtask

  task automatic ser_push(input int ch, input logic [7:0] b, input logic [7:0] t);
    @(negedge clk);
    if (rxq[ch].size() < 64) rxq[ch].push_back({t, b});
    else rxo[ch] = 1'b1;
    rx_push[ch] = 1'b1; rx_byte[ch*8 +: 8] = b; rx_tag[ch*8 +: 8] = t;
    @(posedge clk);
    #1 rx_push = '0;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    tx_pop = '0; rx_push = '0; rx_byte = '0; rx_tag = '0;
    txo = '{1'b0, 1'b0}; rxo = '{1'b0, 1'b0}; scr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset rdata", bus_rdata, 32'd0);
    check("R10 reset tx_empty", 32'(tx_empty), 32'd3);
    rst_n = 1'b1;
    lvl_read(0, 4'b1111, "R7 reset level");
    dev_read(0, 9'h084, 4'b1111, "R8 scratch reset");

    // R2: full word, then middle lanes
    tx_write(0, 4'b1111, 32'h44332211);
    for (int i = 0; i < 4; i++) ser_pop(0);
    tx_write(0, 4'b0110, 32'h00BBAA00);
    lvl_read(0, 4'b0001, "R7/R2 tx count after 2-lane write");
    ser_pop(0); ser_pop(0); ser_pop(0);

    // R3 / R1: channel 1 receive, upper lanes
    ser_push(1, 8'hA1, 8'h01); ser_push(1, 8'hA2, 8'h02); ser_push(1, 8'hA3, 8'h83);
    rx_read(0, 4'b1111, "R1 ch0 empty while ch1 filled");
    rx_read(1, 4'b1100, "R3 upper-lane data read");
    // R4
    ser_push(1, 8'hA4, 8'h44);
    pair_read(1, 4'b0001, "R4 8-bit paired read");
    lvl_read(1, 4'b0010, "R4 no pop on bad pair");
    pair_read(1, 4'b1111, "R4 32-bit paired read");
    // R5 empty / short
    rx_read(1, 4'b1111, "R5 empty read");
    ser_push(1, 8'h5A, 8'h00);
    rx_read(1, 4'b1111, "R5 short read");
    // R9 hold across a write
    ser_push(0, 8'h77, 8'h07);
    rx_read(0, 4'b0001, "R3 single byte");
    tx_write(1, 4'b0001, 32'h000000EE);
    check("R9 rdata held across write", bus_rdata, 32'h00000077);
    ser_pop(1);

    // R6 transmit overflow
    for (int i = 0; i < 17; i++) tx_write(1, 4'b1111, 32'h03020100 + 32'h04040404 * i);
    lvl_read(1, 4'b0011, "R6 full count, flag not cleared");
    lvl_read(1, 4'b0111, "R6 overflow flag set");
    lvl_read(1, 4'b0111, "R6 overflow flag cleared");
    for (int i = 0; i < 64; i++) ser_pop(1);
    // R6 receive overflow
    for (int i = 0; i < 66; i++) ser_push(0, 8'(i), 8'(i ^ 8'h5C));
    check("R6 rx_full", 32'(rx_full), 32'd1);
    lvl_read(0, 4'b0111, "R6 rx overflow flag");
    for (int i = 0; i < 16; i++) pair_read(0, 4'b1111, "R6 rx kept oldest");

    // R8 device window
    scr_write(4'b0010, 32'h0000BE00);
    scr_write(4'b1100, 32'hCAFE0000);
    dev_read(0, 9'h084, 4'b1111, "R8 scratch per-lane write");
    dev_read(0, 9'h080, 4'b1111, "R8 count snapshot");
    dev_read(0, 9'h08C, 4'b1111, "R8 reserved reads zero");
    dev_read(1, 9'h084, 4'b1111, "R8 ch1 device offset zero");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int ch = int'($urandom % 2);
      case ($urandom % 8)
        0, 1: ser_push(ch, 8'($urandom), 8'($urandom));
        2: ser_pop(ch);
        3: tx_write(ch, rand_be(), $urandom);
        4: rx_read(ch, rand_be(), "R3 random data read");
        5: begin
             logic [3:0] pb;
             case ($urandom % 4)
               0: pb = 4'b0011; 1: pb = 4'b1100; 2: pb = 4'b1111; default: pb = rand_be();
             endcase
             pair_read(ch, pb, "R4 random paired read");
           end
        6: lvl_read(ch, rand_be(), "R7 random level read");
        default: dev_read(0, 9'h080, rand_be(), "R8 random snapshot");
      endcase
    end

    // drain
    for (int c = 0; c < 2; c++) begin
      while (txq[c].size() > 0) ser_pop(c);
      while (rxq[c].size() > 0) rx_read(c, 4'b1111, "R3 drain");
      lvl_read(c, 4'b1111, "R7 final level");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule